// File: doc/BRIEF.md
# Forward-Error-Correction Packet Output Formatter

This block sits after a block decoder and turns its corrected byte stream into a parallel output bus with framing signals. Each block carries 204 bytes: 188 payload bytes followed by 16 parity bytes. The block tracks the position of every accepted byte inside its block. It marks the first byte of each block with a sync strobe and flags payload against parity. It also emits one byte-clock pulse per byte, and drives a block error signal from the decoder's per-block uncorrectable flag.

Four configuration inputs shape the output. The first stops the byte clock during parity bytes. The second inverts the byte clock. The third rewrites an inverted sync byte (0xB8) at the head of a block to the normal sync value 0x47. The fourth chooses between passing the parity bytes through and blanking them to zero. The position counter restarts at any start-of-block marker, including one that arrives in the middle of a block, and it wraps by itself after the last parity byte.

Top module: `fec_out_formatter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_data`, `out_sync`, `out_is_data` and `out_err` are 0, and `out_byte_clk` equals `cfg_clk_invert`.
- R2: A byte accepted (`in_valid` high) at a rising clock edge appears on the outputs right after that same edge, one register stage later. With `in_valid` low the outputs other than the byte clock and sync strobe hold their values.
- R3: `out_is_data` is 1 for block positions 0 to 187 and 0 for positions 188 to 203.
- R4: Without gating, `out_byte_clk` is at its active level for exactly one cycle per accepted byte. It sits at its inactive level in cycles that follow an edge with no accepted byte.
- R5: With `cfg_gate_parity` = 1, no byte-clock pulse is produced for bytes at positions 188 to 203. Payload bytes still pulse.
- R6: The active level of `out_byte_clk` is 1 when `cfg_clk_invert` = 0 and 0 when it is 1.
- R7: `out_sync` is 1 for exactly the output cycle of the byte at position 0 and 0 otherwise.
- R8: With `cfg_sync_restore` = 1, a position-0 byte of value 0xB8 is output as 0x47. Any other value, and any byte at another position, is output unchanged. With `cfg_sync_restore` = 0, 0xB8 at position 0 is output unchanged.
- R9: With `cfg_parity_pass` = 1, parity bytes are output unchanged. With `cfg_parity_pass` = 0, they are output as 0x00, and payload bytes are unaffected.
- R10: `in_uncorr` is sampled only with a position-0 byte. `out_err` takes that value in the position-0 output cycle and holds it until the next position-0 byte.
- R11: An accepted byte with `in_sos` = 1 is treated as position 0 whatever the previous count was. `in_sos` has no effect while `in_valid` is 0.
- R12: After position 203 the next accepted byte without `in_sos` is position 0. The first byte after reset is position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte qualifier |
| in_data | input | 8 | Decoded byte |
| in_sos | input | 1 | Start-of-block marker, sampled with `in_valid` |
| in_uncorr | input | 1 | Block uncorrectable flag, sampled with the position-0 byte |
| cfg_gate_parity | input | 1 | Stop byte clock during parity bytes |
| cfg_clk_invert | input | 1 | Invert byte clock |
| cfg_sync_restore | input | 1 | Rewrite 0xB8 sync to 0x47 |
| cfg_parity_pass | input | 1 | 1: output parity bytes, 0: blank them |
| out_data | output | 8 | Output byte |
| out_byte_clk | output | 1 | Byte clock pulse |
| out_sync | output | 1 | First-byte-of-block strobe |
| out_is_data | output | 1 | 1 for payload, 0 for parity |
| out_err | output | 1 | Block uncorrectable indication |

## Verification
Every output result is due one register stage after the edge that accepts its byte. The byte clock level also follows `cfg_clk_invert` directly. The bench drives each byte on a falling edge, waits for the accepting rising edge, and samples 1 ns later. Every output is therefore compared in the cycle right after acceptance. Idle checks sample one cycle after an edge with `in_valid` low, so they observe the held data and the inactive clock level. Error-hold checks drive the opposite `in_uncorr` value on every non-sync byte.

// File: rtl/fec_fmt_pkg.sv
`timescale 1ns/1ps
package fec_fmt_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam logic [7:0]  SYNC_NORM = 8'h47;
    localparam logic [7:0]  SYNC_FLIP = 8'hB8;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              stb;
        logic              sync;
        logic              is_data;
    } fmt_beat_t;

    function automatic logic [BYTE_W-1:0] shape_byte(
        input logic [BYTE_W-1:0] d,
        input logic              first,
        input logic              payload,
        input logic              restore,
        input logic              pass_parity
    );
        if (first && restore && d == SYNC_FLIP)
            return SYNC_NORM;
        else if (!payload && !pass_parity)
            return '0;
        else
            return d;
    endfunction

endpackage

// File: rtl/fec_fmt_pos.sv
`timescale 1ns/1ps
module fec_fmt_pos #(
    parameter int unsigned BLOCK_LEN  = 204,
    parameter int unsigned PARITY_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_sos,
    output logic is_first,
    output logic is_data
);
    localparam int unsigned DATA_LEN = BLOCK_LEN - PARITY_LEN;
    localparam int unsigned POS_W    = $clog2(BLOCK_LEN);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(BLOCK_LEN - 1);
    localparam logic [POS_W-1:0] DATA_END = POS_W'(DATA_LEN);

    logic [POS_W-1:0] cnt_q;
    logic [POS_W-1:0] pos;

    assign pos      = in_sos ? '0 : cnt_q;
    assign is_first = (pos == '0);
    assign is_data  = (pos < DATA_END);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (in_valid)
            cnt_q <= (pos == LAST_POS) ? '0 : pos + 1'b1;
    end

    // R12
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_POS);

    // R11
    resync_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sos) |=> (cnt_q == POS_W'(1)));

endmodule

// File: rtl/fec_fmt_byte_path.sv
`timescale 1ns/1ps
module fec_fmt_byte_path
    import fec_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              is_first,
    input  logic              is_data,
    input  logic              cfg_gate_parity,
    input  logic              cfg_sync_restore,
    input  logic              cfg_parity_pass,
    output fmt_beat_t         beat_q
);
    fmt_beat_t beat_d;

    always_comb begin
        beat_d.data    = shape_byte(in_data, is_first, is_data,
                                    cfg_sync_restore, cfg_parity_pass);
        beat_d.stb     = in_valid && !(cfg_gate_parity && !is_data);
        beat_d.sync    = in_valid && is_first;
        beat_d.is_data = is_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (in_valid) begin
            beat_q <= beat_d;
        end else begin
            beat_q.stb  <= 1'b0;
            beat_q.sync <= 1'b0;
        end
    end

    // R5
    gated_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_data && cfg_gate_parity) |=> !beat_q.stb);

    // R4
    stb_source_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!beat_q.stb && !beat_q.sync));

endmodule

// File: rtl/fec_fmt_err_hold.sv
`timescale 1ns/1ps
module fec_fmt_err_hold (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic is_first,
    input  logic in_uncorr,
    output logic err_q
);
    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (in_valid && is_first)
            err_q <= in_uncorr;
    end

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && is_first) |=> $stable(err_q));

endmodule

// File: rtl/fec_out_formatter.sv
`timescale 1ns/1ps
module fec_out_formatter
    import fec_fmt_pkg::*;
#(
    parameter int unsigned BLOCK_LEN  = 204,
    parameter int unsigned PARITY_LEN = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sos,
    input  logic       in_uncorr,
    input  logic       cfg_gate_parity,
    input  logic       cfg_clk_invert,
    input  logic       cfg_sync_restore,
    input  logic       cfg_parity_pass,
    output logic [7:0] out_data,
    output logic       out_byte_clk,
    output logic       out_sync,
    output logic       out_is_data,
    output logic       out_err
);
    logic      is_first;
    logic      is_data;
    fmt_beat_t beat;

    fec_fmt_pos #(
        .BLOCK_LEN (BLOCK_LEN),
        .PARITY_LEN(PARITY_LEN)
    ) u_pos (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_sos  (in_sos),
        .is_first(is_first),
        .is_data (is_data)
    );

    fec_fmt_byte_path u_path (
        .clk             (clk),
        .rst             (rst),
        .in_valid        (in_valid),
        .in_data         (in_data),
        .is_first        (is_first),
        .is_data         (is_data),
        .cfg_gate_parity (cfg_gate_parity),
        .cfg_sync_restore(cfg_sync_restore),
        .cfg_parity_pass (cfg_parity_pass),
        .beat_q          (beat)
    );

    fec_fmt_err_hold u_err (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .is_first (is_first),
        .in_uncorr(in_uncorr),
        .err_q    (out_err)
    );

    assign out_data     = beat.data;
    assign out_sync     = beat.sync;
    assign out_is_data  = beat.is_data;
    assign out_byte_clk = beat.stb ^ cfg_clk_invert;

    // R7
    sync_in_payload_chk: assert property (@(posedge clk) disable iff (rst)
        out_sync |-> out_is_data);

    // R8
    sync_restored_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_first && cfg_sync_restore) |=> (out_data != SYNC_FLIP));

    // R9
    parity_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_data && !cfg_parity_pass) |=> (out_data == 8'h00));

endmodule

// File: tb/fec_out_formatter_test.sv
`timescale 1ns/1ps
module fec_out_formatter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sos = 1'b0;
    logic       in_uncorr = 1'b0;
    logic       cfg_gate_parity = 1'b0;
    logic       cfg_clk_invert = 1'b0;
    logic       cfg_sync_restore = 1'b0;
    logic       cfg_parity_pass = 1'b1;
    logic [7:0] out_data;
    logic       out_byte_clk;
    logic       out_sync;
    logic       out_is_data;
    logic       out_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fec_out_formatter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_sos(in_sos), .in_uncorr(in_uncorr),
        .cfg_gate_parity(cfg_gate_parity), .cfg_clk_invert(cfg_clk_invert),
        .cfg_sync_restore(cfg_sync_restore), .cfg_parity_pass(cfg_parity_pass),
        .out_data(out_data), .out_byte_clk(out_byte_clk), .out_sync(out_sync),
        .out_is_data(out_is_data), .out_err(out_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int p);
        return 8'((p * 7 + 3) & 8'hFF);
    endfunction

    // Push one byte at position p and check every output one stage later.
    task automatic push_chk(input logic [7:0] d, input logic sos, input logic unc,
                            input int p, input logic eerr);
        logic [7:0] ed;
        logic       ecl;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sos = sos; in_uncorr = unc;
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_sos = 1'b0;
        if (p == 0 && cfg_sync_restore && d == 8'hB8) ed = 8'h47;
        else if (p >= 188 && !cfg_parity_pass)       ed = 8'h00;
        else                                          ed = d;
        ecl = !(cfg_gate_parity && p >= 188);
        chk("R2/R8/R9 data", {24'd0, out_data}, {24'd0, ed});
        chk("R3 is_data", {31'd0, out_is_data}, {31'd0, (p < 188)});
        chk("R7 sync", {31'd0, out_sync}, {31'd0, (p == 0)});
        chk("R4/R5/R6 byte clk", {31'd0, out_byte_clk}, {31'd0, ecl ^ cfg_clk_invert});
        chk("R10 err", {31'd0, out_err}, {31'd0, eerr});
    endtask

    task automatic idle_chk(input logic [7:0] held, input logic eerr);
        @(negedge clk);
        in_valid = 1'b0; in_sos = 1'b1; in_data = 8'hEE;
        @(posedge clk);
        #1;
        in_sos = 1'b0;
        chk("R4 idle clk", {31'd0, out_byte_clk}, {31'd0, cfg_clk_invert});
        chk("R2 idle data hold", {24'd0, out_data}, {24'd0, held});
        chk("R7 idle sync", {31'd0, out_sync}, 32'd0);
        chk("R10 idle err", {31'd0, out_err}, {31'd0, eerr});
    endtask

    task automatic full_block(input logic [7:0] head, input logic unc, input logic use_sos);
        for (int p = 0; p < 204; p++) begin
            logic [7:0] d;
            d = (p == 0) ? head : pat(p);
            push_chk(d, (p == 0) && use_sos, (p == 0) ? unc : !unc, p, unc);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 data", {24'd0, out_data}, 32'd0);
        chk("R1 sync", {31'd0, out_sync}, 32'd0);
        chk("R1 is_data", {31'd0, out_is_data}, 32'd0);
        chk("R1 err", {31'd0, out_err}, 32'd0);
        chk("R1 clk", {31'd0, out_byte_clk}, {31'd0, cfg_clk_invert});
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 after release clk", {31'd0, out_byte_clk}, {31'd0, cfg_clk_invert});
        chk("R1 after release sync", {31'd0, out_sync}, 32'd0);
    endtask

    // First byte after reset with no marker is position 0; plain block, wrap.
    task automatic t_plain_and_wrap;
        cfg_gate_parity = 0; cfg_parity_pass = 1; cfg_sync_restore = 0; cfg_clk_invert = 0;
        full_block(8'h47, 1'b0, 1'b0);           // R12 first byte after reset
        full_block(8'h47, 1'b1, 1'b0);           // R12 wrap without marker
    endtask

    task automatic t_gate_blank_restore;
        cfg_gate_parity = 1; cfg_parity_pass = 0; cfg_sync_restore = 1;
        full_block(8'hB8, 1'b0, 1'b1);           // R5 R8 R9
        idle_chk(8'h00, 1'b0);                   // R11 marker ignored without valid
        full_block(8'h47, 1'b1, 1'b0);           // R11: idle marker had no effect
    endtask

    task automatic t_restore_off_and_other_pos;
        cfg_gate_parity = 0; cfg_parity_pass = 1; cfg_sync_restore = 0;
        push_chk(8'hB8, 1'b1, 1'b0, 0, 1'b0);    // R8 disabled
        cfg_sync_restore = 1;
        push_chk(8'hB8, 1'b0, 1'b1, 1, 1'b0);    // R8 non-zero position unchanged
        push_chk(8'h12, 1'b0, 1'b1, 2, 1'b0);
        idle_chk(8'h12, 1'b0);                   // R4 R2 gap
        push_chk(8'h34, 1'b0, 1'b1, 3, 1'b0);
    endtask

    task automatic t_resync_mid;
        for (int p = 4; p < 60; p++) push_chk(pat(p), 1'b0, 1'b0, p, 1'b0);
        push_chk(8'hB8, 1'b1, 1'b1, 0, 1'b1);    // R11 mid-block resync, R10 new err
        for (int p = 1; p < 204; p++) push_chk(pat(p), 1'b0, 1'b0, p, 1'b1);
        push_chk(8'h47, 1'b0, 1'b0, 0, 1'b0);    // R12 wrap clears err
    endtask

    task automatic t_invert;
        cfg_clk_invert = 1; cfg_gate_parity = 1; cfg_parity_pass = 1;
        idle_chk(8'h47, 1'b0);                   // R6 inactive level
        for (int p = 1; p < 204; p++) push_chk(pat(p), 1'b0, 1'b1, p, 1'b0);  // R6 R5
        idle_chk(pat(203), 1'b0);
        cfg_clk_invert = 0;
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_plain_and_wrap();
        t_gate_blank_restore();
        t_restore_off_and_other_pos();
        t_resync_mid();
        t_invert();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule